// File: doc/BRIEF.md
# Speculative Bus Cycle Start Controller

The block sits between a processor's access sequencer and its external bus. When an instruction or data access request is accepted and the bus is idle, it raises an early cycle-start strobe while the internal caches are searched in parallel. If the lookup reports a hit in the strobe clock, the external cycle is dropped and address strobe is never raised. On a miss the cycle continues: address strobe rises on the next clock and stays up until the slave terminates the cycle.

When the bus is busy at acceptance, no speculative start is made. A hit then leaves no trace on the bus. A miss waits for the bus to free up and then runs a normal cycle. An operand-start strobe marks the first cycle of an operand that actually goes external, which handles the case of a two-part misaligned operand whose first part hit. A fill-enable pulse tells the cache that returned data may be written. A parameter sets the minimum number of idle clocks between a negation of cycle-start and its next assertion.

Top module: `spec_cyc_ctrl`

## Requirements
- R1: After reset, cyc_start_o, opr_start_o, addr_strobe_o and fill_en_o are low and req_ready_o is high.
- R2: A request accepted (req_valid_i and req_ready_o high) with bus_busy_i low and the gap rule met raises cyc_start_o in the following clock. The lookup result hit_i is sampled in that clock.
- R3: A hit in the cycle-start clock aborts the cycle, and addr_strobe_o stays low. In that same clock the controller is ready for a new request, so strobes for hits may appear on consecutive clocks with instruction and data requests mixed.
- R4: A miss in the cycle-start clock raises addr_strobe_o on the next clock. It is held until term_i or abort_term_i is sampled high, and drops on the clock after that.
- R5: A request accepted while bus_busy_i is high gives no cycle-start. A hit then produces no output activity. A miss waits until bus_busy_i is low, then gives a one-clock cyc_start_o followed by addr_strobe_o.
- R6: opr_start_o is high only together with cyc_start_o. It is high on every cycle-start of a request with req_part2_i low (unsplit operand or first part).
- R7: For a second part (req_part2_i high), opr_start_o goes with its cycle-start only if the preceding first part produced no cycle-start at all (a speculative start that was later aborted counts as a start).
- R8: An instruction request (req_data_i low) is not ready in the clock directly after an accepted instruction request. Data requests (req_data_i high) are not limited this way.
- R9: fill_en_o is high, in the termination clock only, when term_i is high with abort_term_i and inhibit_i low. An abnormal termination or inhibit_i blocks it.
- R10: Between a negation of cyc_start_o and its next assertion at least GAP_CYCLES clocks pass with it low. With GAP_CYCLES of 0 a new strobe may follow directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_data_i | input | 1 | 1 = data access, 0 = instruction prefetch |
| req_part2_i | input | 1 | Request is the second part of a misaligned operand |
| hit_i | input | 1 | Cache lookup hit, valid in the clock after acceptance |
| bus_busy_i | input | 1 | Bus occupied by another read or write |
| term_i | input | 1 | Normal cycle termination |
| abort_term_i | input | 1 | Abnormal cycle termination |
| inhibit_i | input | 1 | Slave forbids caching of returned data |
| req_ready_o | output | 1 | Request can be accepted this clock |
| cyc_start_o | output | 1 | Early cycle-start strobe |
| opr_start_o | output | 1 | Operand cycle-start strobe |
| addr_strobe_o | output | 1 | Address strobe of a cycle that goes external |
| fill_en_o | output | 1 | Returned data may be written into the cache |

## Verification
On every cycle, the assertions check these rules: no address strobe after an aborted start, a strobe held until termination and raised after every unaborted start, no speculative start while the bus is busy, operand-start only within cycle-start, the prefetch pacing, and the idle gap. Only the bench scenarios can show which strobe carries operand-start across a two-part operand, the exact clocks in which a waiting cycle leaves the bus-busy phase, the fill decision under each of the three termination kinds, and runs of consecutive hit strobes with mixed request types.

// File: rtl/spec_cyc_pkg.sv
package spec_cyc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_START = 3'd3,
    ST_ADDR  = 3'd4
  } cyc_state_e;
endpackage

// File: rtl/spec_cyc_gap.sv
module spec_cyc_gap #(
  parameter int GAP_CYCLES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_start_i,
  output logic gap_ok_o
);
  if (GAP_CYCLES == 0) begin : g_nogap
    assign gap_ok_o = 1'b1;
  end else begin : g_gap
    localparam int CW = $clog2(GAP_CYCLES + 2);
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (cyc_start_i) cnt_q <= CW'(GAP_CYCLES);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
    // ok means a strobe may be raised in the next clock
    assign gap_ok_o = !cyc_start_i && (cnt_q <= CW'(1));

    // independent low-run tracker for the check
    logic [CW-1:0] run_q;
    logic          prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q  <= CW'(GAP_CYCLES);
        prev_q <= 1'b0;
      end else begin
        prev_q <= cyc_start_i;
        if (cyc_start_i)                  run_q <= '0;
        else if (run_q < CW'(GAP_CYCLES)) run_q <= run_q + 1'b1;
      end
    end
    // R10
    gap_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_start_i && !prev_q) |-> (run_q >= CW'(GAP_CYCLES)));
  end
endmodule

// File: rtl/spec_cyc_pacer.sv
module spec_cyc_pacer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic is_data_i,
  output logic inst_ok_o
);
  logic inst_last_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inst_last_q <= 1'b0;
    else         inst_last_q <= acc_i && !is_data_i;
  end
  assign inst_ok_o = !inst_last_q;

  // R8
  inst_pace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !is_data_i) |=> !(acc_i && !is_data_i));
endmodule

// File: rtl/spec_cyc_opr.sv
module spec_cyc_opr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic part2_i,
  input  logic cyc_start_i,
  output logic opr_start_o
);
  logic part2_q, first_ext_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part2_q     <= 1'b0;
      first_ext_q <= 1'b0;
    end else begin
      if (acc_i) part2_q <= part2_i;
      // first part starts fresh; any strobe of it marks the operand as external
      if (acc_i && !part2_i)             first_ext_q <= 1'b0;
      else if (cyc_start_i && !part2_q)  first_ext_q <= 1'b1;
    end
  end
  assign opr_start_o = cyc_start_i && (!part2_q || !first_ext_q);

  // R6
  opr_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opr_start_o |-> cyc_start_i);
endmodule

// File: rtl/spec_cyc_ctrl.sv
module spec_cyc_ctrl
  import spec_cyc_pkg::*;
#(
  parameter int GAP_CYCLES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_data_i,
  input  logic req_part2_i,
  input  logic hit_i,
  input  logic bus_busy_i,
  input  logic term_i,
  input  logic abort_term_i,
  input  logic inhibit_i,
  output logic req_ready_o,
  output logic cyc_start_o,
  output logic opr_start_o,
  output logic addr_strobe_o,
  output logic fill_en_o
);
  cyc_state_e state_q, state_d;
  logic spec_q, spec_d;
  logic gap_ok, inst_ok, free, accept, done;

  assign free        = (state_q == ST_IDLE) || (state_q == ST_LOOK && hit_i);
  assign req_ready_o = free && (req_data_i || inst_ok);
  assign accept      = req_valid_i && req_ready_o;
  assign done        = term_i || abort_term_i;

  always_comb begin
    state_d = state_q;
    spec_d  = spec_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LOOK;
      ST_LOOK: begin
        if (hit_i)       state_d = accept ? ST_LOOK : ST_IDLE;
        else if (spec_q) state_d = ST_ADDR;
        else             state_d = ST_WAIT;
      end
      ST_WAIT:  if (!bus_busy_i && gap_ok) state_d = ST_START;
      ST_START: state_d = ST_ADDR;
      ST_ADDR:  if (done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (accept) spec_d = !bus_busy_i && gap_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      spec_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      spec_q  <= spec_d;
    end
  end

  assign cyc_start_o   = (state_q == ST_LOOK && spec_q) || (state_q == ST_START);
  assign addr_strobe_o = (state_q == ST_ADDR);
  assign fill_en_o     = addr_strobe_o && term_i && !abort_term_i && !inhibit_i;

  spec_cyc_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_start_i(cyc_start_o), .gap_ok_o(gap_ok)
  );

  spec_cyc_pacer u_pacer (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(accept), .is_data_i(req_data_i),
    .inst_ok_o(inst_ok)
  );

  spec_cyc_opr u_opr (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(accept), .part2_i(req_part2_i),
    .cyc_start_i(cyc_start_o), .opr_start_o(opr_start_o)
  );

  // R3
  abort_no_as_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOK && spec_q && hit_i) |=> !addr_strobe_o);
  // R4
  miss_as_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_o && !(state_q == ST_LOOK && hit_i)) |=> addr_strobe_o);
  // R4
  as_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_strobe_o && !done) |=> addr_strobe_o);
  // R5
  busy_no_spec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && bus_busy_i) |=> !cyc_start_o);
  // R9
  fill_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_o |=> !addr_strobe_o);
endmodule

// File: tb/spec_cyc_ctrl_test.sv
`timescale 1ns/1ps
module spec_cyc_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req, dat, p2, hit, busy, term, abrt, inh;
  logic rdy, cs, os, as_o, fe;
  logic g_req, g_hit, g_term;
  logic g_rdy, g_cs, g_os, g_as, g_fe;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  spec_cyc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .req_data_i(dat),
    .req_part2_i(p2), .hit_i(hit), .bus_busy_i(busy), .term_i(term),
    .abort_term_i(abrt), .inhibit_i(inh), .req_ready_o(rdy),
    .cyc_start_o(cs), .opr_start_o(os), .addr_strobe_o(as_o), .fill_en_o(fe)
  );

  spec_cyc_ctrl #(.GAP_CYCLES(2)) uut_gap (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(g_req), .req_data_i(1'b1),
    .req_part2_i(1'b0), .hit_i(g_hit), .bus_busy_i(1'b0), .term_i(g_term),
    .abort_term_i(1'b0), .inhibit_i(1'b0), .req_ready_o(g_rdy),
    .cyc_start_o(g_cs), .opr_start_o(g_os), .addr_strobe_o(g_as), .fill_en_o(g_fe)
  );

  typedef struct { string r; logic [4:0] e; } item_t;
  item_t sbq[$];
  item_t it;

  // monitor: compare {ready, cs, os, as, fill} mid-cycle
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      checks++;
      if ({rdy, cs, os, as_o, fe} !== it.e) begin
        bad++;
        $display("FAIL %s act=%b exp=%b", it.r, {rdy, cs, os, as_o, fe}, it.e);
      end
    end
  end

  // in = {req, data, part2, hit, busy, term, abort, inhibit}
  task automatic step(input string r, input logic [7:0] in, input logic [4:0] e);
    item_t x;
    @(posedge clk); #1;
    {req, dat, p2, hit, busy, term, abrt, inh} = in;
    x.r = r; x.e = e;
    sbq.push_back(x);
  endtask

  task automatic gstep(input string r, input logic rq, input logic h, input logic t,
                       input logic ecs, input logic eas);
    @(posedge clk); #1;
    g_req = rq; g_hit = h; g_term = t;
    @(negedge clk);
    checks++;
    if ({g_cs, g_as} !== {ecs, eas}) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", r, {g_cs, g_as}, {ecs, eas});
    end
  endtask

  initial begin
    {req, dat, p2, hit, busy, term, abrt, inh} = '0;
    {g_req, g_hit, g_term} = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step("R1 reset", 8'b0000_0000, 5'b10000);

    // R2 R4 R6 R9: data miss, normal fill
    step("R2 accept",   8'b1100_0000, 5'b10000);
    step("R2 cs",       8'b0000_0000, 5'b01100);
    step("R4 as",       8'b0000_0000, 5'b00010);
    step("R9 fill",     8'b0000_0100, 5'b00011);
    step("R4 as drop",  8'b0000_0000, 5'b10000);

    // R9: abnormal termination blocks fill
    step("R9 acc",      8'b1100_0000, 5'b10000);
    step("R9 cs",       8'b0000_0000, 5'b01100);
    step("R9 abort",    8'b0000_0010, 5'b00010);
    step("R9 idle",     8'b0000_0000, 5'b10000);
    // R9: inhibit blocks fill
    step("R9 acc",      8'b1100_0000, 5'b10000);
    step("R9 cs",       8'b0000_0000, 5'b01100);
    step("R9 inhibit",  8'b0000_0101, 5'b00010);
    step("R9 idle",     8'b0000_0000, 5'b10000);

    // R3 R8: consecutive hit strobes, mixed types
    step("R3 inst acc", 8'b1000_0000, 5'b10000);
    step("R3 hit+data", 8'b1101_0000, 5'b11100);
    step("R3 hit+inst", 8'b1001_0000, 5'b11100);
    step("R8 inst held",8'b1001_0000, 5'b01100);
    step("R8 inst acc", 8'b1000_0000, 5'b10000);
    step("R8 not rdy",  8'b0001_0000, 5'b01100);
    step("R3 no as",    8'b0000_0000, 5'b10000);

    // R5: busy bus, hit then miss
    step("R5 acc busy", 8'b1100_1000, 5'b10000);
    step("R5 hit quiet",8'b0001_1000, 5'b10000);
    step("R5 acc busy", 8'b1100_1000, 5'b10000);
    step("R5 miss",     8'b0000_1000, 5'b00000);
    step("R5 wait",     8'b0000_1000, 5'b00000);
    step("R5 free",     8'b0000_0000, 5'b00000);
    step("R5 cs",       8'b0000_0000, 5'b01100);
    step("R5 as term",  8'b0000_0100, 5'b00011);
    step("R5 idle",     8'b0000_0000, 5'b10000);

    // R7: first part hit with no start -> second part carries opr
    step("R7 p1 busy",  8'b1100_1000, 5'b10000);
    step("R7 p1 hit",   8'b1111_0000, 5'b10000);
    step("R7 p2 opr",   8'b0000_0000, 5'b01100);
    step("R7 term",     8'b0000_0100, 5'b00011);
    step("R7 idle",     8'b0000_0000, 5'b10000);
    // R7 R6: first part started then aborted -> second part has no opr
    step("R6 p1 acc",   8'b1100_0000, 5'b10000);
    step("R6 p1 opr",   8'b1111_0000, 5'b11100);
    step("R7 p2 noopr", 8'b0000_0000, 5'b01000);
    step("R7 term",     8'b0000_0100, 5'b00011);
    step("R7 idle",     8'b0000_0000, 5'b10000);

    repeat (3) @(posedge clk);

    // R10: GAP_CYCLES=2 instance
    gstep("R10 acc",    1, 0, 0, 0, 0);
    gstep("R10 cs hit", 1, 1, 0, 1, 0);
    gstep("R10 low1",   0, 0, 0, 0, 0);
    gstep("R10 low2",   0, 0, 0, 0, 0);
    gstep("R10 cs",     0, 0, 0, 1, 0);
    gstep("R10 as",     0, 0, 1, 0, 1);
    gstep("R10 idle",   0, 0, 0, 0, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule